// File: doc/BRIEF.md
# Dual-Compare 16-bit Timer Channel

This block is a single 16-bit counter/timer channel driven from a small register bus. Software programs two compare limits (A and B), the count register and a control word. The channel then counts ticks from one of three sources. The first is a fixed internal tick at one quarter of the clock rate. The second is a prescale tick that another timer supplies. The third is the rising edge of the timer input pin, synchronised to the clock. When the count matches the active limit, the channel can raise a one-clock interrupt request, drive its output pin and, in one-shot use, stop itself.

Two compare modes are provided. Single mode counts against limit A and drops the output low for one clock on each match. Dual mode runs a phase against limit A and then a phase against limit B. The output is high during the A phase and low during the B phase, and a status bit shows which limit is active. A lock bit in each control write decides whether that write may change the run bit. Under internal clocking the input pin can serve as a retrigger that clears the count.

Top module: `dctimer`

## Requirements
- R1: After reset the count, both limits and the control word read 0, the output pin is high and no interrupt request is active.
- R2: Control word layout: bit0 continuous, bit1 dual, bit2 retrigger, bit3 prescale select, bit4 external clock, bit5 interrupt enable, bit6 phase-B status (read-only), bit14 lock (write-only, reads 0), bit15 run. A control write with bit14 set updates every field except run, and run keeps its previous value. With bit14 clear, run takes bit15.
- R3: In single mode each enabled tick adds one to the count. On the tick whose new value would equal limit A, the count returns to 0 and the output pin is low for exactly the next clock.
- R4: In dual mode a match against A switches to phase B and a match against B switches back to phase A, with the count returning to 0 each time. The output pin is high in phase A and low in phase B, and bit6 of the control word reads 1 in phase B.
- R5: With interrupt enable set, each match (A or B) produces a one-clock interrupt request in the clock after the matching tick. With it clear, no request is produced.
- R6: With continuous clear, run clears itself when a timing cycle ends: the A match in single mode, or the B match in dual mode. After that, ticks no longer change the count. With continuous set, counting goes on.
- R7: Under internal clocking with retrigger set, a rising edge on the timer input pin clears the count.
- R8: With external clock set, each rising edge of the input pin advances the count by one, after a two-flop synchroniser. In this mode the prescale tick and the retrigger bit have no effect.
- R9: A limit of 0 is treated as 65536 ticks: from 0xFFFF the next tick matches and the count returns to 0.
- R10: With both external clock and prescale select clear, the count advances once every 4 clocks while running.
- R11: Register addresses: 0 count, 1 limit A, 2 limit B, 3 control. A write to address 0 loads the count, and this takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr (combinational) |
| timerIn | input | 1 | Timer input pin (external clock or retrigger) |
| prescaleTick | input | 1 | One-clock tick from another timer |
| timerOut | output | 1 | Timer output pin |
| irqPulse | output | 1 | One-clock interrupt request |

## Verification
Single mode is run with a small limit to show the one-clock low pulse on the output and the return of the count to zero. Dual mode is then run with two different limits. This separates the A and B phases through the output level and the status bit, and shows that a request is raised on both kinds of match. One-shot runs in each mode show the point at which run clears. A run with the input pin under external clocking, with the prescale tick pulsing, shows that only the pin edges count and that retrigger is inert. A run under internal clocking shows the pin acting as a clear instead. A limit of zero started from 0xFFFF and a free run on the fixed tick check the wrap and the divide-by-4 rate.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_MAXA  = 2'd1,
    REG_MAXB  = 2'd2,
    REG_CTRL  = 2'd3
  } regSel_e;

  // control word bit positions
  localparam int B_CONT  = 0;
  localparam int B_DUAL  = 1;
  localparam int B_RETRG = 2;
  localparam int B_PRESC = 3;
  localparam int B_EXT   = 4;
  localparam int B_IRQEN = 5;
  localparam int B_PHASE = 6;
  localparam int B_LOCK  = 14;
  localparam int B_RUN   = 15;

  typedef struct packed {
    logic contin;
    logic dual;
    logic retrig;
    logic preSel;
    logic extClk;
    logic irqEn;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic clearCnt;
    logic loadCnt;
    logic loadA;
    logic loadB;
    logic selB;
  } strobe_t;

endpackage

// File: rtl/dctimer_ctrl.sv
module dctimer_ctrl
  import dctimer_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIX_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              timerIn,
  input  logic              prescaleTick,
  input  logic              hit,
  output strobe_t           stb,
  output cfg_t              cfg,
  output logic              run,
  output logic              phaseB,
  output logic              timerOut,
  output logic              irqPulse,
  output logic [DATA_W-1:0] ctrlRead
);

  localparam int DIV_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

  logic [2:0] inPipe;
  logic       inRise;
  logic       fixTick;
  logic       srcTick;
  logic       ctrlWr;
  logic       cycleEnd;
  logic       pulseLow;
  logic       unusedWdata;

  assign unusedWdata = ^{regWdata[B_LOCK-1:B_PHASE], regWdata[DATA_W-1:B_RUN]};

  // two synchroniser flops plus one history flop for edge detection
  assign inRise = inPipe[1] & ~inPipe[2];

  generate
    if (FIX_DIV <= 1) begin : g_noDiv
      assign fixTick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DIV_W'(FIX_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign fixTick = (divCnt == DIV_W'(FIX_DIV - 1));
    end
  endgenerate

  assign ctrlWr  = regWe && (regAddr == REG_CTRL);
  assign srcTick = cfg.extClk ? inRise : (cfg.preSel ? prescaleTick : fixTick);

  always_comb begin
    stb.loadCnt  = regWe && (regAddr == REG_COUNT);
    stb.loadA    = regWe && (regAddr == REG_MAXA);
    stb.loadB    = regWe && (regAddr == REG_MAXB);
    stb.clearCnt = !cfg.extClk && cfg.retrig && inRise && !stb.loadCnt;
    stb.advance  = run && srcTick && !stb.loadCnt && !stb.clearCnt;
    stb.selB     = phaseB;
  end

  assign cycleEnd = hit && (!cfg.dual || phaseB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPipe   <= '0;
      cfg      <= '0;
      run      <= 1'b0;
      phaseB   <= 1'b0;
      pulseLow <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      inPipe   <= {inPipe[1:0], timerIn};
      pulseLow <= hit && !cfg.dual;
      irqPulse <= hit && cfg.irqEn;

      if (ctrlWr) begin
        cfg.contin <= regWdata[B_CONT];
        cfg.dual   <= regWdata[B_DUAL];
        cfg.retrig <= regWdata[B_RETRG];
        cfg.preSel <= regWdata[B_PRESC];
        cfg.extClk <= regWdata[B_EXT];
        cfg.irqEn  <= regWdata[B_IRQEN];
      end

      if (ctrlWr && !regWdata[B_LOCK]) run <= regWdata[B_RUN];
      else if (cycleEnd && !cfg.contin) run <= 1'b0;

      if (ctrlWr) phaseB <= 1'b0;
      else if (!cfg.dual) phaseB <= 1'b0;
      else if (hit) phaseB <= ~phaseB;
    end
  end

  assign timerOut = cfg.dual ? ~phaseB : ~pulseLow;

  always_comb begin
    ctrlRead          = '0;
    ctrlRead[B_CONT]  = cfg.contin;
    ctrlRead[B_DUAL]  = cfg.dual;
    ctrlRead[B_RETRG] = cfg.retrig;
    ctrlRead[B_PRESC] = cfg.preSel;
    ctrlRead[B_EXT]   = cfg.extClk;
    ctrlRead[B_IRQEN] = cfg.irqEn;
    ctrlRead[B_PHASE] = phaseB;
    ctrlRead[B_RUN]   = run;
  end

endmodule

// File: rtl/dctimer_dp.sv
module dctimer_dp
  import dctimer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] regWdata,
  output logic              hit,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] maxA,
  output logic [DATA_W-1:0] maxB
);

  logic [DATA_W-1:0] cntPlus;
  logic [DATA_W-1:0] target;

  assign cntPlus = count + 1'b1;
  assign target  = stb.selB ? maxB : maxA;
  // a limit of 0 matches when the count wraps, giving 2**DATA_W ticks
  assign hit     = stb.advance && (cntPlus == target);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      maxA  <= '0;
      maxB  <= '0;
    end else begin
      if (stb.loadCnt) count <= regWdata;
      else if (stb.clearCnt) count <= '0;
      else if (stb.advance) count <= hit ? '0 : cntPlus;

      if (stb.loadA) maxA <= regWdata;
      if (stb.loadB) maxB <= regWdata;
    end
  end

endmodule

// File: rtl/dctimer.sv
module dctimer
  import dctimer_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIX_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              timerIn,
  input  logic              prescaleTick,
  output logic              timerOut,
  output logic              irqPulse
);

  strobe_t           stb;
  cfg_t              cfg;
  logic              hit;
  logic              run;
  logic              phaseB;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] maxA;
  logic [DATA_W-1:0] maxB;
  logic [DATA_W-1:0] ctrlRead;

  dctimer_ctrl #(.DATA_W(DATA_W), .FIX_DIV(FIX_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .timerIn(timerIn), .prescaleTick(prescaleTick),
    .hit(hit), .stb(stb), .cfg(cfg), .run(run), .phaseB(phaseB),
    .timerOut(timerOut), .irqPulse(irqPulse), .ctrlRead(ctrlRead)
  );

  dctimer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .hit(hit), .count(count), .maxA(maxA), .maxB(maxB)
  );

  always_comb begin
    unique case (regAddr)
      REG_COUNT: regRdata = count;
      REG_MAXA:  regRdata = maxA;
      REG_MAXB:  regRdata = maxB;
      default:   regRdata = ctrlRead;
    endcase
  end

endmodule

// File: rtl/dctimer_chk.sv
module dctimer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic       timerOut,
  input logic       irqPulse,
  input logic       hit,
  input logic       run,
  input logic       phaseB,
  input logic       dual,
  input logic       contin,
  input logic       irqEn
);

  logic ctrlWr;
  assign ctrlWr = regWe && (regAddr == 2'd3);

  a_r3_single_low: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !dual && !ctrlWr) |=> !timerOut);

  a_r3_low_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    (!dual && !timerOut && !hit && !ctrlWr) |=> timerOut);

  a_r4_a_to_b: assert property (@(posedge clk) disable iff (!rstN)
    (hit && dual && !phaseB && !ctrlWr) |=> (phaseB && !timerOut));

  a_r4_b_to_a: assert property (@(posedge clk) disable iff (!rstN)
    (hit && dual && phaseB && !ctrlWr) |=> (!phaseB && timerOut));

  a_r5_irq_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (hit && irqEn) |=> irqPulse);

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(hit));

  a_r6_one_shot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !contin && (!dual || phaseB) && !ctrlWr) |=> !run);

endmodule

bind dctimer dctimer_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .timerOut(timerOut), .irqPulse(irqPulse), .hit(hit), .run(run),
  .phaseB(phaseB), .dual(cfg.dual), .contin(cfg.contin), .irqEn(cfg.irqEn)
);

// File: tb/sim_dctimer.sv
module sim_dctimer;

  localparam logic [15:0] RUN  = 16'h8000;
  localparam logic [15:0] LOCK = 16'h4000;
  localparam logic [15:0] PHB  = 16'h0040;
  localparam logic [15:0] IRQ  = 16'h0020;
  localparam logic [15:0] EXT  = 16'h0010;
  localparam logic [15:0] PRE  = 16'h0008;
  localparam logic [15:0] RET  = 16'h0004;
  localparam logic [15:0] DUAL = 16'h0002;
  localparam logic [15:0] CONT = 16'h0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic        timerIn = 1'b0;
  logic        prescaleTick = 1'b0;
  logic        timerOut;
  logic        irqPulse;

  int total = 0;
  int bad = 0;
  logic expQ[$];

  always #4 clk = ~clk;

  dctimer u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .timerIn(timerIn),
    .prescaleTick(prescaleTick), .timerOut(timerOut), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic tick();
    @(negedge clk);
    prescaleTick = 1'b1;
    @(negedge clk);
    prescaleTick = 1'b0;
  endtask

  task automatic pinPulse();
    @(negedge clk); timerIn = 1'b1;
    repeat (4) @(negedge clk);
    timerIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected output level during a request
  task automatic expectIrq(input logic outLevel);
    expQ.push_back(outLevel);
  endtask

  // monitor side: every request must match a queued expectation (R5)
  always @(negedge clk) begin
    if (rstN && irqPulse) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R5: actual=unexpected request expected=none");
      end else begin
        logic e;
        e = expQ.pop_front();
        if (timerOut !== e) begin
          bad++;
          $display("FAIL R5: actual=out %b expected=out %b", timerOut, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 16'h0);
    rd(2'd1, v); check("R1 maxA", v, 16'h0);
    rd(2'd2, v); check("R1 maxB", v, 16'h0);
    rd(2'd3, v); check("R1 ctrl", v, 16'h0);
    check("R1 out", {15'd0, timerOut}, 16'd1);
    check("R1 irq", {15'd0, irqPulse}, 16'd0);

    // R2 lock bit protects run
    wr(2'd3, RUN | LOCK | IRQ | PRE);
    rd(2'd3, v); check("R2 locked enable", v, IRQ | PRE);
    wr(2'd3, RUN | IRQ | PRE | CONT);
    rd(2'd3, v); check("R2 unlocked enable", v, RUN | IRQ | PRE | CONT);
    wr(2'd3, LOCK | IRQ | PRE | CONT);
    rd(2'd3, v); check("R2 locked keep run", v, RUN | IRQ | PRE | CONT);

    // R3 single mode, R11 load
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd0);
    tick(); tick();
    rd(2'd0, v); check("R3 count before match", v, 16'd2);
    expectIrq(1'b0);
    tick();
    check("R3 out low on match", {15'd0, timerOut}, 16'd0);
    @(negedge clk);
    check("R3 out high after one clock", {15'd0, timerOut}, 16'd1);
    rd(2'd0, v); check("R3 count wraps", v, 16'd0);
    wr(2'd0, 16'h1234);
    rd(2'd0, v); check("R11 count load", v, 16'h1234);

    // R4 dual mode
    wr(2'd3, RUN | IRQ | PRE | CONT | DUAL);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'd0);
    check("R4 out high phase A", {15'd0, timerOut}, 16'd1);
    tick();
    expectIrq(1'b0);
    tick();
    check("R4 out low phase B", {15'd0, timerOut}, 16'd0);
    rd(2'd3, v); check("R4 status phase B", v, RUN | IRQ | PRE | CONT | DUAL | PHB);
    tick(); tick();
    expectIrq(1'b1);
    tick();
    check("R4 out high back in A", {15'd0, timerOut}, 16'd1);
    rd(2'd3, v); check("R4 status phase A", v, RUN | IRQ | PRE | CONT | DUAL);

    // R5 no request when disabled
    wr(2'd3, RUN | PRE | CONT | DUAL);
    tick(); tick();
    @(negedge clk);
    check("R5 match without request", {15'd0, timerOut}, 16'd0);

    // R6 one-shot single
    wr(2'd3, RUN | IRQ | PRE);
    wr(2'd0, 16'd0);
    tick();
    expectIrq(1'b0);
    tick();
    rd(2'd3, v); check("R6 single stops", v, IRQ | PRE);
    tick(); tick();
    rd(2'd0, v); check("R6 no count when stopped", v, 16'd0);

    // R6 one-shot dual
    wr(2'd3, RUN | IRQ | PRE | DUAL);
    wr(2'd0, 16'd0);
    tick();
    expectIrq(1'b0);
    tick();
    rd(2'd3, v); check("R6 dual runs after A", v, RUN | IRQ | PRE | DUAL | PHB);
    tick(); tick();
    expectIrq(1'b1);
    tick();
    rd(2'd3, v); check("R6 dual stops after B", v, IRQ | PRE | DUAL);

    // R7 retrigger under internal clocking
    wr(2'd3, RUN | PRE | CONT | RET);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'd0);
    repeat (5) tick();
    rd(2'd0, v); check("R7 count before retrigger", v, 16'd5);
    pinPulse();
    rd(2'd0, v); check("R7 retrigger clears", v, 16'd0);

    // R8 external clock
    wr(2'd3, RUN | PRE | CONT | RET | EXT);
    wr(2'd0, 16'd0);
    repeat (3) tick();
    rd(2'd0, v); check("R8 prescale ignored", v, 16'd0);
    pinPulse();
    rd(2'd0, v); check("R8 first edge counts", v, 16'd1);
    pinPulse();
    rd(2'd0, v); check("R8 second edge counts, no clear", v, 16'd2);

    // R9 zero limit
    wr(2'd3, RUN | IRQ | PRE | CONT);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'hFFFE);
    tick();
    rd(2'd0, v); check("R9 count reaches FFFF", v, 16'hFFFF);
    expectIrq(1'b0);
    tick();
    rd(2'd0, v); check("R9 wraps to 0", v, 16'h0);

    // R10 fixed tick divide by 4
    wr(2'd1, 16'd100);
    wr(2'd3, RUN | CONT);
    wr(2'd0, 16'd0);
    repeat (39) @(posedge clk);
    #1;
    regAddr = 2'd0;
    #1 check("R10 fixed tick rate", regRdata, 16'd10);
    wr(2'd3, 16'h0);

    repeat (4) @(negedge clk);
    check("R5 all expected requests seen", 16'(expQ.size()), 16'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule